// File: doc/BRIEF.md
# Hardware Text Cursor Generator

This block marks one character cell of a text display with a cursor band. The raster timing logic feeds it, on every character clock, the linear memory address of the cell being fetched, the scan-line number inside the current character row, and the display-enable flag. The block compares that address against a software-programmed cursor address. It also checks that the scan line falls between a programmed top line and bottom line. When both hold while the picture is visible and the cursor is enabled, it raises a one-bit cursor-video signal. Downstream logic overlays that signal on the character stream.

Software programs the block through a small byte-wide register port with four slots. Two slots hold the top and bottom lines of the band and can only be written. The other two hold the upper and lower bytes of the 16-bit cursor address, and these can be written and read back. A top line of zero starts the band at the first line of the row, which gives a full block when the bottom is the last line. A top line below the last line the row uses, or above the bottom line, hides the cursor. An address outside the visible area never matches a displayed cell, so no cursor is drawn. Blink timing is not generated here. A plain enable input gates the output so that an external blink source can drive it.

Top module: `text_cursor_gen`

## Requirements
- R1: After a synchronous active-low reset, the cursor address reads back as 0, both band lines are 0, and `cursor_vid` is 0.
- R2: A write with `reg_sel` = 2 loads `reg_wdata` into address bits 15:8, and a write with `reg_sel` = 3 loads bits 7:0. Each byte takes effect on its own at the clock edge of the write, and the other byte is left unchanged.
- R3: `reg_rdata` combinationally returns address bits 15:8 for `reg_sel` = 2 and bits 7:0 for `reg_sel` = 3. It returns 0 for `reg_sel` = 0 and 1, the write-only band slots.
- R4: A write with `reg_sel` = 0 sets the band top line, and one with `reg_sel` = 1 sets the bottom line, each from `reg_wdata[3:0]`. The cursor is drawn on a scan line `s` exactly when top <= `s` <= bottom. Both limits are inclusive.
- R5: When the top line is greater than the bottom line, no scan line draws the cursor.
- R6: `cursor_vid` stays 0 for any cell whose address differs from the cursor address, even by one bit.
- R7: `cursor_vid` stays 0 while `disp_en` is low, even when the address and the scan line match.
- R8: `cursor_vid` stays 0 while `cursor_on` is low.
- R9: `cursor_vid` is registered. It reflects the inputs presented in the cycle before, exactly one clock after they were sampled.
- R10: When a register write and a matching comparison fall in the same cycle, the comparison uses the register contents from before that write. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register slot: 0 top line, 1 bottom line, 2 address high, 3 address low |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected slot |
| mem_addr | input | 16 | Linear memory address of the current cell |
| row_line | input | 4 | Scan line inside the current character row |
| disp_en | input | 1 | High while the raster is in the visible area |
| cursor_on | input | 1 | Cursor enable, for an external blink source |
| cursor_vid | output | 1 | Registered cursor-video signal |

## Verification
A register write and the cell comparison can fall in the same cycle. Software may move the cursor while the raster is sitting on the old cell or the new one. The bench provokes this in both directions. In one case it writes an address byte that turns the cursor away from the cell being presented. In the other it writes a byte that turns the cursor onto it. It then judges that the first case still shows the cursor, that the second does not, and that the cycle after the write follows the new address. The band limits are swept over every top, bottom and scan-line combination, and the result is compared with the inclusive range computed in the bench.

// File: rtl/cursor_pkg.sv
// Shared definitions for the text cursor generator.
// Assumes a two-bit slot select on the register port.
package cursor_pkg;

    // Register slot encodings; address slots are ordered low byte last
    typedef enum logic [1:0] {
        SLOT_LINE_TOP = 2'd0,
        SLOT_LINE_BOT = 2'd1,
        SLOT_ADDR_HI  = 2'd2,
        SLOT_ADDR_LO  = 2'd3
    } cur_slot_e;

    // Number of byte lanes making up the cursor address
    localparam int unsigned ADDR_LANES = 2;

endpackage

// File: rtl/cursor_regs.sv
// Cursor register file: band top/bottom lines (write-only) and a cursor
// address split into byte lanes (read/write). Writes land on the clock edge;
// readback is combinational. Assumes a synchronous active-low reset.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LINE_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [1:0]                         sel,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [DATA_W-1:0]                  rdata,
    output logic [ADDR_LANES*DATA_W-1:0]       cur_addr,
    output logic [LINE_W-1:0]                  line_top,
    output logic [LINE_W-1:0]                  line_bot
);

    localparam int unsigned ADDR_W = ADDR_LANES * DATA_W;

    cur_slot_e slot;
    assign slot = cur_slot_e'(sel);

    // One storage byte per address lane, selected by its own slot code
    for (genvar g = 0; g < ADDR_LANES; g++) begin : g_lane
        localparam cur_slot_e LANE_SLOT = (g == 0) ? SLOT_ADDR_LO : SLOT_ADDR_HI;
        logic [DATA_W-1:0] lane_q;

        // Load this lane when its slot is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (wr_en && (slot == LANE_SLOT)) begin
                lane_q <= wdata;
            end
        end

        assign cur_addr[g*DATA_W +: DATA_W] = lane_q;
    end

    // Band top and bottom line storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_top <= '0;
            line_bot <= '0;
        end else if (wr_en) begin
            if (slot == SLOT_LINE_TOP) line_top <= wdata[LINE_W-1:0];
            if (slot == SLOT_LINE_BOT) line_bot <= wdata[LINE_W-1:0];
        end
    end

    // Readback mux: address lanes only, band slots read as zero
    always_comb begin
        unique case (slot)
            SLOT_ADDR_HI: rdata = cur_addr[ADDR_W-1 -: DATA_W];
            SLOT_ADDR_LO: rdata = cur_addr[DATA_W-1:0];
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/cursor_match.sv
// Cell comparator: flags when the raster's memory address equals the cursor
// address. Compares per byte lane, then combines. Purely combinational.
module cursor_match #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic [LANES*DATA_W-1:0] mem_addr,
    input  logic [LANES*DATA_W-1:0] cur_addr,
    output logic                    cell_hit
);

    logic [LANES-1:0] lane_eq;

    // Per-lane equality
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign lane_eq[g] = (mem_addr[g*DATA_W +: DATA_W] == cur_addr[g*DATA_W +: DATA_W]);
    end

    assign cell_hit = &lane_eq;

endmodule

// File: rtl/cursor_band.sv
// Band detector: flags when the current scan line lies inside the inclusive
// top..bottom range. An inverted range (top > bottom) never matches.
module cursor_band #(
    parameter int unsigned LINE_W = 4
) (
    input  logic [LINE_W-1:0] row_line,
    input  logic [LINE_W-1:0] line_top,
    input  logic [LINE_W-1:0] line_bot,
    output logic              in_band
);

    // Inclusive range test against both limits
    always_comb begin
        in_band = (row_line >= line_top) && (row_line <= line_bot);
    end

endmodule

// File: rtl/text_cursor_gen.sv
// Hardware text cursor generator top. Combines cell match, band test,
// display enable and cursor enable, and registers the result so that it sits
// one stage after the memory address it was compared against. Comparisons in
// a write cycle use the register contents from before that write.
module text_cursor_gen
    import cursor_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LINE_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr_en,
    input  logic [1:0]                    reg_sel,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [ADDR_LANES*DATA_W-1:0]  mem_addr,
    input  logic [LINE_W-1:0]             row_line,
    input  logic                          disp_en,
    input  logic                          cursor_on,
    output logic                          cursor_vid
);

    localparam int unsigned ADDR_W = ADDR_LANES * DATA_W;

    logic [ADDR_W-1:0] cur_addr;
    logic [LINE_W-1:0] line_top;
    logic [LINE_W-1:0] line_bot;
    logic              cell_hit;
    logic              in_band;

    cursor_regs #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cur_addr (cur_addr),
        .line_top (line_top),
        .line_bot (line_bot)
    );

    cursor_match #(.DATA_W(DATA_W), .LANES(ADDR_LANES)) u_match (
        .mem_addr (mem_addr),
        .cur_addr (cur_addr),
        .cell_hit (cell_hit)
    );

    cursor_band #(.LINE_W(LINE_W)) u_band (
        .row_line (row_line),
        .line_top (line_top),
        .line_bot (line_bot),
        .in_band  (in_band)
    );

    // Output stage: register the gated cursor decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor_vid <= 1'b0;
        end else begin
            cursor_vid <= disp_en && cursor_on && cell_hit && in_band;
        end
    end

endmodule

// File: rtl/cursor_chk.sv
// Assertion checker for text_cursor_gen, attached by bind below.
module cursor_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LINE_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr_en,
    input logic [1:0]            reg_sel,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [2*DATA_W-1:0]   mem_addr,
    input logic [LINE_W-1:0]     row_line,
    input logic                  disp_en,
    input logic                  cursor_on,
    input logic                  cursor_vid,
    input logic [2*DATA_W-1:0]   cur_addr,
    input logic [LINE_W-1:0]     line_top,
    input logic [LINE_W-1:0]     line_bot
);

    // R2: a high-byte write lands in the upper lane next cycle
    assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr_en) && $past(reg_sel) == 2'd2)
            |-> cur_addr[2*DATA_W-1:DATA_W] == $past(reg_wdata));

    // R4: a drawn cursor had its scan line inside the band one cycle earlier
    assert_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_vid |-> ($past(row_line) >= $past(line_top) && $past(row_line) <= $past(line_bot)));

    // R6 / R10: a drawn cursor matched the address held in the prior cycle
    assert_cell_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_vid |-> $past(mem_addr) == $past(cur_addr));

    // R7: no cursor outside the visible area
    assert_de_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_vid |-> $past(disp_en));

    // R8: no cursor while disabled
    assert_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_vid |-> $past(cursor_on));

endmodule

bind text_cursor_gen cursor_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_cursor_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .mem_addr   (mem_addr),
    .row_line   (row_line),
    .disp_en    (disp_en),
    .cursor_on  (cursor_on),
    .cursor_vid (cursor_vid),
    .cur_addr   (cur_addr),
    .line_top   (line_top),
    .line_bot   (line_bot)
);

// File: tb/tb_text_cursor_gen.sv
`timescale 1ns/1ps
module tb_text_cursor_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] mem_addr = 16'd0;
    logic [3:0]  row_line = 4'd0;
    logic        disp_en = 1'b0;
    logic        cursor_on = 1'b0;
    logic        cursor_vid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    text_cursor_gen dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
        .row_line(row_line), .disp_en(disp_en), .cursor_on(cursor_on),
        .cursor_vid(cursor_vid)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    // Present one cell and return the output one clock later
    task automatic probe(input logic [15:0] a, input logic [3:0] ln,
                         input logic de, input logic en, output logic got);
        @(negedge clk);
        mem_addr = a; row_line = ln; disp_en = de; cursor_on = en;
        @(negedge clk);
        got = cursor_vid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic       o;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd2, rb); check("R1 addr hi", {8'd0, rb}, 16'h0);
        rd(2'd3, rb); check("R1 addr lo", {8'd0, rb}, 16'h0);
        check("R1 cursor_vid", {15'd0, cursor_vid}, 16'h0);
        probe(16'h0000, 4'd0, 1'b1, 1'b1, o);
        check("R1 band 0..0 at line 0", {15'd0, o}, 16'h1);
        probe(16'h0000, 4'd1, 1'b1, 1'b1, o);
        check("R1 band 0..0 at line 1", {15'd0, o}, 16'h0);

        // R2 / R3: independent byte writes and readback
        wr(2'd2, 8'h12);
        rd(2'd2, rb); check("R2 hi after hi write", {8'd0, rb}, 16'h12);
        rd(2'd3, rb); check("R2 lo untouched", {8'd0, rb}, 16'h00);
        wr(2'd3, 8'h34);
        rd(2'd3, rb); check("R2 lo after lo write", {8'd0, rb}, 16'h34);
        rd(2'd2, rb); check("R2 hi untouched", {8'd0, rb}, 16'h12);
        wr(2'd0, 8'h05);
        rd(2'd0, rb); check("R3 top slot reads zero", {8'd0, rb}, 16'h0);
        wr(2'd1, 8'h0A);
        rd(2'd1, rb); check("R3 bottom slot reads zero", {8'd0, rb}, 16'h0);

        // R4 / R5: exhaustive band sweep at address 0x1234
        for (int t = 0; t < 16; t++) begin
            for (int b = 0; b < 16; b++) begin
                wr(2'd0, 8'(t));
                wr(2'd1, 8'(b));
                for (int s = 0; s < 16; s++) begin
                    probe(16'h1234, 4'(s), 1'b1, 1'b1, o);
                    if (t > b)
                        check("R5 inverted band", {15'd0, o}, 16'h0);
                    else
                        check("R4 inclusive band", {15'd0, o}, {15'd0, (s >= t && s <= b)});
                end
            end
        end

        // Band 3..6 for the remaining tests
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd6);

        // R6: single-bit address differences
        for (int k = 0; k < 16; k++) begin
            probe(16'h1234 ^ (16'h1 << k), 4'd4, 1'b1, 1'b1, o);
            check("R6 one-bit mismatch", {15'd0, o}, 16'h0);
        end
        probe(16'h1234, 4'd4, 1'b1, 1'b1, o);
        check("R6 exact match", {15'd0, o}, 16'h1);

        // R7: display enable gate
        probe(16'h1234, 4'd4, 1'b0, 1'b1, o);
        check("R7 disp_en low", {15'd0, o}, 16'h0);

        // R8: cursor enable gate
        probe(16'h1234, 4'd4, 1'b1, 1'b0, o);
        check("R8 cursor_on low", {15'd0, o}, 16'h0);

        // R9: exactly one clock of latency
        probe(16'h0000, 4'd4, 1'b1, 1'b1, o);
        @(negedge clk);
        mem_addr = 16'h1234; row_line = 4'd4; disp_en = 1'b1; cursor_on = 1'b1;
        #1 check("R9 not yet", {15'd0, cursor_vid}, 16'h0);
        @(negedge clk);
        check("R9 one clock later", {15'd0, cursor_vid}, 16'h1);
        mem_addr = 16'h0000;
        @(negedge clk);
        check("R9 drops one clock after", {15'd0, cursor_vid}, 16'h0);

        // R10: write away from the presented cell; old address still matches
        @(negedge clk);
        mem_addr = 16'h1234; reg_wr_en = 1'b1; reg_sel = 2'd3; reg_wdata = 8'h35;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R10 old address used in write cycle", {15'd0, cursor_vid}, 16'h1);
        @(negedge clk);
        check("R10 new address applies next cycle", {15'd0, cursor_vid}, 16'h0);

        // R10: write onto the presented cell; no cursor in the write cycle
        @(negedge clk);
        mem_addr = 16'h5635; reg_wr_en = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h56;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R10 new address not used in write cycle", {15'd0, cursor_vid}, 16'h0);
        @(negedge clk);
        check("R10 new address matches next cycle", {15'd0, cursor_vid}, 16'h1);

        disp_en = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule